// File: doc/BRIEF.md
# Exception Coprocessor Control Unit

This block is the system control coprocessor for a 32-bit pipelined processor. It keeps three architectural registers: the exception program counter (EPC), the status word and the cause word. The pipeline offers it one synchronous fault per cycle, with a 5-bit code, the PC of the instruction at the commit point and a flag that says whether that instruction sits in a branch delay slot. External interrupt lines are sampled into the cause word as pending bits.

When a fault or an enabled interrupt is accepted, the unit saves the return address and the cause, raises the exception-level bit and, in the same cycle, asks the fetch stage to redirect to the fixed handler vector. While the exception-level bit is high, no further exception or interrupt is accepted. A return request redirects fetch to the saved EPC and drops the exception-level bit. Software reaches the registers through a combinational read port feeding the general-register write path and a one-cycle write port.

Top module: `excCop`

## Requirements
- R1: After reset, status reads 0x00000002 (exception level 1, interrupt enable 0, mask 0, user mode 0), cause reads 0 and EPC reads 0, and no redirect is requested.
- R2: A fault request while exception level is 0 raises `redirect` in the same cycle with `redirectPc` = 0x80000180; after the clock edge, EPC holds the fault PC, cause bits 6:2 hold the fault code and status bit 1 (exception level) is 1.
- R3: If the accepted fault is flagged as in a delay slot, EPC receives the PC minus 4 and cause bit 31 becomes 1; otherwise cause bit 31 becomes 0.
- R4: While status bit 1 is 1, fault requests and interrupts raise no redirect and change neither EPC nor cause code.
- R5: A return request raises `redirect` in the same cycle with `redirectPc` equal to EPC; after the edge, status bit 1 is 0.
- R6: A write to register 12 stores bits 15:8 (mask), 4 (user mode), 1 (exception level) and 0 (interrupt enable), all other status bits read 0; a write to register 14 stores all 32 bits of EPC; a write to register 13 has no effect.
- R7: The read port returns status for 12, cause for 13, EPC for 14 and zero for every other register number.
- R8: Cause bits 15:8 show the interrupt lines as sampled at the previous clock edge.
- R9: An interrupt is accepted only when status bit 0 is 1, status bit 1 is 0 and some pending bit is set together with its mask bit; it records code 0 and EPC = PC.
- R10: When a fault and an acceptable interrupt arrive in the same cycle, the fault's code is recorded.
- R11: A register write issued in the same cycle as an accepted exception or a return request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Synchronous fault request from the pipeline |
| excCode | input | 5 | Fault code |
| excPc | input | 32 | PC of the instruction at the commit point |
| excInDelay | input | 1 | That instruction is in a branch delay slot |
| irqIn | input | IRQ_W | External interrupt lines |
| eretReq | input | 1 | Return-from-exception request |
| cpSel | input | 5 | Coprocessor register number for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Value to write |
| rdData | output | 32 | Selected register value |
| redirect | output | 1 | Fetch redirect request |
| redirectPc | output | 32 | Redirect target |

## Verification
The bench builds the unit with its defaults: eight interrupt lines and the handler at 0x80000180. With all eight lines present, a pending pattern such as 0x05 can be set against a mask that covers none of its bits and then one that covers exactly one, so both the blocked and the accepted interrupt cases are reached. Each scenario is timed so that redirect outputs are sampled in the request cycle and register contents one edge later. The directed sequence also reaches the corners where a fault and an interrupt collide, where a write meets an accepted exception or a return, and where a request arrives while the exception level is raised.

// File: rtl/excCopPkg.sv
package excCopPkg;
  localparam logic [4:0] REG_STATUS = 5'd12;
  localparam logic [4:0] REG_CAUSE  = 5'd13;
  localparam logic [4:0] REG_EPC    = 5'd14;

  typedef struct packed {
    logic take;   // an exception or interrupt is accepted this cycle
    logic isIrq;  // the accepted event is an interrupt
    logic eret;   // a return is performed this cycle
    logic write;  // a register write is performed this cycle
  } copStrobe_t;
endpackage

// File: rtl/excCopCtrl.sv
module excCopCtrl
  import excCopPkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excReq,
  input  logic             eretReq,
  input  logic             wrEn,
  input  logic             exl,
  input  logic             ie,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic [IRQ_W-1:0] irqPend,
  output copStrobe_t       strb
);
  logic syncHit;
  logic irqHit;

  always_comb begin
    syncHit    = excReq & ~exl;
    irqHit     = ie & ~exl & (|(irqPend & irqMask));
    strb.take  = syncHit | irqHit;
    strb.isIrq = irqHit & ~syncHit;
    strb.eret  = eretReq & ~strb.take;
    strb.write = wrEn & ~strb.take & ~eretReq;
  end

  // R4: with the level bit up and no return, nothing is accepted
  p_hold_exl_r4: assert property (@(posedge clk) disable iff (!rstN)
    (exl && !eretReq) |-> !strb.take && !strb.write || !strb.take);

  // R10: a fault in the same cycle as an interrupt is never recorded as the interrupt
  p_sync_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && strb.take) |-> !strb.isIrq);

  // R11: writes never coincide with an accepted exception or a return
  p_write_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |-> !strb.take && !eretReq);
endmodule

// File: rtl/excCopDp.sv
module excCopDp
  import excCopPkg::*;
#(
  parameter int          IRQ_W       = 8,
  parameter logic [31:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rstN,
  input  copStrobe_t       strb,
  input  logic [4:0]       excCode,
  input  logic [31:0]      excPc,
  input  logic             excInDelay,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic [4:0]       cpSel,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             redirect,
  output logic [31:0]      redirectPc,
  output logic             exl,
  output logic             ie,
  output logic [IRQ_W-1:0] irqMask,
  output logic [IRQ_W-1:0] irqPend
);
  logic [31:0]      epcQ;
  logic [7:0]       maskQ;
  logic             umQ;
  logic             exlQ;
  logic             ieQ;
  logic             bdQ;
  logic [4:0]       codeQ;
  logic [IRQ_W-1:0] pendQ;
  logic [7:0]       pendWide;
  logic [31:0]      statusWord;
  logic [31:0]      causeWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ  <= '0;
      maskQ <= '0;
      umQ   <= 1'b0;
      exlQ  <= 1'b1;
      ieQ   <= 1'b0;
      bdQ   <= 1'b0;
      codeQ <= '0;
      pendQ <= '0;
    end else begin
      pendQ <= irqIn;
      if (strb.take) begin
        exlQ  <= 1'b1;
        bdQ   <= excInDelay;
        codeQ <= strb.isIrq ? 5'd0 : excCode;
        epcQ  <= excInDelay ? (excPc - 32'd4) : excPc;
      end else if (strb.eret) begin
        exlQ <= 1'b0;
      end else if (strb.write) begin
        if (cpSel == REG_STATUS) begin
          maskQ <= wrData[15:8];
          umQ   <= wrData[4];
          exlQ  <= wrData[1];
          ieQ   <= wrData[0];
        end else if (cpSel == REG_EPC) begin
          epcQ <= wrData;
        end
      end
    end
  end

  always_comb begin
    pendWide            = '0;
    pendWide[IRQ_W-1:0] = pendQ;
    statusWord = {16'd0, maskQ, 3'd0, umQ, 2'd0, exlQ, ieQ};
    causeWord  = {bdQ, 15'd0, pendWide, 1'b0, codeQ, 2'd0};
    case (cpSel)
      REG_STATUS: rdData = statusWord;
      REG_CAUSE:  rdData = causeWord;
      REG_EPC:    rdData = epcQ;
      default:    rdData = '0;
    endcase
    redirect   = strb.take | strb.eret;
    redirectPc = strb.take ? HANDLER_VEC : epcQ;
    exl        = exlQ;
    ie         = ieQ;
    irqMask    = maskQ[IRQ_W-1:0];
    irqPend    = pendQ;
  end

  // R2: accepting an exception raises the level bit
  p_exl_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> exlQ);

  // R3: delay-slot faults save the branch address and flag it
  p_delay_epc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && excInDelay) |=> (epcQ == $past(excPc) - 32'd4) && bdQ);

  // R5: a return leaves the level bit cleared
  p_eret_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.eret |=> !exlQ);

  // R8: pending bits follow the lines one edge late
  p_pend_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pendQ == $past(irqIn));
endmodule

// File: rtl/excCop.sv
module excCop
  import excCopPkg::*;
#(
  parameter int          IRQ_W       = 8,
  parameter logic [31:0] HANDLER_VEC = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excReq,
  input  logic [4:0]       excCode,
  input  logic [31:0]      excPc,
  input  logic             excInDelay,
  input  logic [IRQ_W-1:0] irqIn,
  input  logic             eretReq,
  input  logic [4:0]       cpSel,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             redirect,
  output logic [31:0]      redirectPc
);
  copStrobe_t       strb;
  logic             exl;
  logic             ie;
  logic [IRQ_W-1:0] irqMask;
  logic [IRQ_W-1:0] irqPend;

  excCopCtrl #(.IRQ_W(IRQ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .eretReq(eretReq), .wrEn(wrEn),
    .exl(exl), .ie(ie), .irqMask(irqMask), .irqPend(irqPend), .strb(strb)
  );

  excCopDp #(.IRQ_W(IRQ_W), .HANDLER_VEC(HANDLER_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .excCode(excCode), .excPc(excPc),
    .excInDelay(excInDelay), .irqIn(irqIn), .cpSel(cpSel), .wrData(wrData),
    .rdData(rdData), .redirect(redirect), .redirectPc(redirectPc),
    .exl(exl), .ie(ie), .irqMask(irqMask), .irqPend(irqPend)
  );
endmodule

// File: tb/excCop_bench.sv
module excCop_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rstN;
  logic        excReq;
  logic [4:0]  excCode;
  logic [31:0] excPc;
  logic        excInDelay;
  logic [7:0]  irqIn;
  logic        eretReq;
  logic [4:0]  cpSel;
  logic        wrEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        redirect;
  logic [31:0] redirectPc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  excCop u_excCop (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode), .excPc(excPc),
    .excInDelay(excInDelay), .irqIn(irqIn), .eretReq(eretReq), .cpSel(cpSel),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .redirect(redirect),
    .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    excReq = 0; excCode = 0; excInDelay = 0; eretReq = 0; wrEn = 0; wrData = 0;
  endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] v);
    cpSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    cpSel = sel; wrEn = 1; wrData = d;
    step();
    idle();
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(5'd12, v); chk("R1 status", v, 32'h2);
    rd(5'd13, v); chk("R1 cause", v, 32'h0);
    rd(5'd14, v); chk("R1 epc", v, 32'h0);
    chk("R1 redirect", {31'd0, redirect}, 32'd0);
    rd(5'd0, v);  chk("R7 reg0", v, 32'h0);
    rd(5'd31, v); chk("R7 reg31", v, 32'h0);
  endtask

  task automatic tIgnored();
    logic [31:0] v;
    excReq = 1; excCode = 5'd7; excPc = 32'h100;
    #1 chk("R4 no redirect", {31'd0, redirect}, 32'd0);
    step(); idle();
    rd(5'd14, v); chk("R4 epc kept", v, 32'h0);
    rd(5'd13, v); chk("R4 cause kept", v, 32'h0);
  endtask

  task automatic tWrite();
    logic [31:0] v;
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); chk("R6 status mask bits", v, 32'h0000_FF13);
    wr(5'd12, 32'h0000_0000);
    rd(5'd12, v); chk("R6 status clear", v, 32'h0);
    wr(5'd14, 32'h1234_5678);
    rd(5'd14, v); chk("R6 epc write", v, 32'h1234_5678);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R6 cause write ignored", v, 32'h0);
  endtask

  task automatic tSync();
    logic [31:0] v;
    excReq = 1; excCode = 5'd4; excPc = 32'h400; excInDelay = 0;
    #1 chk("R2 redirect", {31'd0, redirect}, 32'd1);
    chk("R2 vector", redirectPc, VEC);
    step(); idle();
    rd(5'd14, v); chk("R2 epc", v, 32'h400);
    rd(5'd13, v); chk("R2 R3 cause code bd0", v, 32'h10);
    rd(5'd12, v); chk("R2 exl set", v, 32'h2);
  endtask

  task automatic tEret(input logic [31:0] expPc, input logic [31:0] expStatus);
    logic [31:0] v;
    eretReq = 1;
    #1 chk("R5 redirect", {31'd0, redirect}, 32'd1);
    chk("R5 target", redirectPc, expPc);
    step(); idle();
    rd(5'd12, v); chk("R5 exl clear", v, expStatus);
  endtask

  task automatic tDelay();
    logic [31:0] v;
    excReq = 1; excCode = 5'd10; excPc = 32'h500; excInDelay = 1;
    step(); idle();
    rd(5'd14, v); chk("R3 epc minus 4", v, 32'h4FC);
    rd(5'd13, v); chk("R3 bd set", v, 32'h8000_0028);
  endtask

  task automatic tWriteDrop();
    logic [31:0] v;
    excReq = 1; excCode = 5'd1; excPc = 32'h600;
    cpSel = 5'd14; wrEn = 1; wrData = 32'hDEAD;
    step(); idle();
    rd(5'd14, v); chk("R11 write dropped on take", v, 32'h600);
    eretReq = 1; cpSel = 5'd14; wrEn = 1; wrData = 32'hBEEF;
    step(); idle();
    rd(5'd14, v); chk("R11 write dropped on eret", v, 32'h600);
    rd(5'd12, v); chk("R5 exl clear after eret", v, 32'h0);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    irqIn = 8'h05;
    step();
    rd(5'd13, v); chk("R8 pending", v, 32'h0000_0504);
    #1 chk("R9 no take ie0", {31'd0, redirect}, 32'd0);
    wr(5'd12, 32'h0000_0201);
    #1 chk("R9 no take mask miss", {31'd0, redirect}, 32'd0);
    excPc = 32'h700;
    wr(5'd12, 32'h0000_0401);
    #1 chk("R9 take", {31'd0, redirect}, 32'd1);
    chk("R9 vector", redirectPc, VEC);
    irqIn = 8'h00;
    step();
    rd(5'd14, v); chk("R9 epc", v, 32'h700);
    rd(5'd13, v); chk("R9 code 0", v, 32'h0);
    rd(5'd12, v); chk("R9 exl", v, 32'h0403);
  endtask

  task automatic tPrio();
    logic [31:0] v;
    tEret(32'h700, 32'h0401);
    irqIn = 8'h04;
    #1 chk("R9 not pending yet", {31'd0, redirect}, 32'd0);
    step();
    excReq = 1; excCode = 5'd12; excPc = 32'h800;
    step(); idle();
    rd(5'd13, v); chk("R10 sync code wins", v, 32'h0000_0430);
    rd(5'd14, v); chk("R10 epc", v, 32'h800);
  endtask

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; idle(); excPc = 0; irqIn = 0; cpSel = 0;
    @(negedge clk); step(); step();
    rstN = 1;
    tReset();
    tIgnored();
    tWrite();
    tSync();
    tEret(32'h400, 32'h0);
    tDelay();
    tEret(32'h4FC, 32'h0);
    tWriteDrop();
    tIrq();
    tPrio();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule